// File: doc/BRIEF.md
# Real-Time Counter with Dual-Clock Control Port

This block keeps a 32-bit count of a slow, free-running clock while a much faster bus clock handles all register traffic. Software reaches the block through a small indirect byte port: four holding bytes that carry a value into or out of the counter, one control and status byte, and four alarm compare bytes. Loading and reading the counter are request bits that software sets and hardware clears. Each request crosses into the slow domain through a toggle handshake, and the bit clears once the acknowledge has come back through a synchronizer.

An alarm compares the running count against the alarm bytes and raises a short event flag on a match. It can also zero the counter on that match, so the counter wraps at a chosen period. A detector on the bus side watches for slow-clock activity and latches a sticky failure flag when the slow clock stops. The oscillator enable works only as a clock-enable on the slow-domain logic.

The register port has no streaming data path. Every pin is a plain control or status signal with no back-pressure: a write takes effect on the bus clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally. Software must not change the holding bytes while a load is pending, and must not change the alarm bytes while the alarm is enabled.

Top module: `rtc_timer`

## Requirements
- R1: After reset, every readable byte reads 0: holding bytes, alarm bytes and control.
- R2: Address map. Holding bytes are at addresses 0 to 3 and alarm bytes at 8 to 11, least significant byte first. Control is at 4. Control bits: 7 oscillator enable, 6 detector enable, 5 fail flag, 4 run, 3 alarm enable, 2 alarm flag / auto-reset, 1 load request, 0 capture request. All written bytes read back, apart from the special control bits listed below.
- R3: With run at 0 the counter holds its value. With run at 1 it advances by one on each enabled slow-clock cycle.
- R4: Writing 1 to bit 1 copies the holding bytes into the counter. Bit 1 reads 1 right after the write and returns to 0 once the copy is done.
- R5: Writing 1 to bit 0 copies the counter into the holding bytes. Bit 0 reads 1 until the copy is done.
- R6: Reading bit 2 returns the alarm event flag. Writing bit 2 sets the auto-reset enable, which does not show up on reads.
- R7: When the alarm is enabled and the counter is running, a count equal to the alarm bytes raises the alarm flag for no longer than one slow-clock cycle.
- R8: Any write to the control byte clears the alarm flag.
- R9: When auto-reset is enabled, an alarm match loads 0 into the counter. When it is disabled, the counter keeps counting past the alarm value.
- R10: When the detector is enabled and no slow-clock activity is seen for MISS_LIMIT bus cycles, the fail flag is set. It stays set until a control write with bit 5 at 0; writing 1 to bit 5 has no effect.
- R11: While the oscillator enable is 0, the slow-domain logic is frozen. A load request stays pending and completes once the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| slow_clk | input | 1 | Slow counting clock |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the bus clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |

## Verification
The counter is driven in several ways: stopped after a load, which must give back the exact loaded value; running for a known time, which gives a bounded range; and running into an alarm with auto-reset on and then off, where a small captured count separates wrap-to-zero from counting straight on. Bit 2 is written with no alarm pending, to show that the write sets auto-reset without setting the flag, and a control write is placed inside a live alarm pulse, to show that the clear wins over the synchronized event. The detector is run with the slow clock active and then with it stopped, and the fail flag is then written first with 1 and then with 0. A load request is issued while the oscillator is off, which shows the request waiting rather than completing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // byte addresses on the register port
  localparam int HOLD_BASE  = 0;
  localparam int CTL_OFS    = 4;
  localparam int ALARM_BASE = 8;
  // control byte bit positions
  localparam int B_OSC  = 7;
  localparam int B_MON  = 6;
  localparam int B_FAIL = 5;
  localparam int B_RUN  = 4;
  localparam int B_AEN  = 3;
  localparam int B_ALRM = 2;
  localparam int B_SET  = 1;
  localparam int B_CAP  = 0;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int CNT_W = 32
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             osc_en_a,
  input  logic             run_a,
  input  logic             aen_a,
  input  logic             arst_a,
  input  logic             set_tgl_a,
  input  logic             cap_tgl_a,
  input  logic [CNT_W-1:0] hold_val,
  input  logic [CNT_W-1:0] alarm_val,
  output logic             set_ack_t,
  output logic             cap_ack_t,
  output logic [CNT_W-1:0] cap_val,
  output logic             evt,
  output logic             beat
);
  logic en_s, run_s, aen_s, arst_s, set_s, cap_s;
  logic [CNT_W-1:0] cnt;
  logic hit;

  rtc_sync #(.W(6)) u_sync_slow (
    .clk  (slow_clk),
    .rst_n(rst_n),
    .d    ({osc_en_a, run_a, aen_a, arst_a, set_tgl_a, cap_tgl_a}),
    .q    ({en_s, run_s, aen_s, arst_s, set_s, cap_s})
  );

  assign hit = aen_s && run_s && (cnt == alarm_val);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      cap_val   <= '0;
      set_ack_t <= 1'b0;
      cap_ack_t <= 1'b0;
      evt       <= 1'b0;
      beat      <= 1'b0;
    end else if (en_s) begin
      beat <= ~beat;
      evt  <= hit && !evt;
      if (set_s != set_ack_t) begin
        cnt       <= hold_val;
        set_ack_t <= set_s;
      end else if (run_s) begin
        cnt <= (hit && arst_s) ? '0 : cnt + CNT_W'(1);
      end
      if (cap_s != cap_ack_t) begin
        cap_val   <= cnt;
        cap_ack_t <= cap_s;
      end
    end
  end
endmodule

// File: rtl/rtc_clkmon.sv
module rtc_clkmon #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic beat_s,
  output logic timeout
);
  localparam int CW = $clog2(LIMIT + 1);
  logic          beat_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_d  <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      beat_d  <= beat_s;
      timeout <= 1'b0;
      if (!enable || (beat_s != beat_d)) begin
        cnt <= '0;
      end else if (cnt < CW'(LIMIT)) begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(LIMIT - 1)) timeout <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
  import rtc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 4,
  parameter int MISS_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  localparam int NB = CNT_W / 8;

  logic [7:0]       hold_b  [NB];
  logic [7:0]       alarm_b [NB];
  logic [CNT_W-1:0] hold_w, alarm_w, cap_val;

  logic osc_en, mon_en, fail_q, run, aen, arst, alrm_q;
  logic set_pend, cap_pend, set_tgl, cap_tgl;
  logic set_ack_t, cap_ack_t, evt, beat;
  logic set_ack_s, cap_ack_s, evt_s, beat_s, evt_d;
  logic mon_timeout, ctl_wr, cap_done;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_pack
      assign hold_w[8*gi +: 8]  = hold_b[gi];
      assign alarm_w[8*gi +: 8] = alarm_b[gi];
    end
  endgenerate

  assign ctl_wr   = reg_wr && (reg_addr == ADDR_W'(CTL_OFS));
  assign cap_done = cap_pend && (cap_ack_s == cap_tgl);

  // holding and alarm bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        hold_b[i]  <= '0;
        alarm_b[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (cap_done) hold_b[i] <= cap_val[8*i +: 8];
        else if (reg_wr && reg_addr == ADDR_W'(HOLD_BASE + i)) hold_b[i] <= reg_wdata;
        if (reg_wr && reg_addr == ADDR_W'(ALARM_BASE + i)) alarm_b[i] <= reg_wdata;
      end
    end
  end

  // control byte and request handshakes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en   <= 1'b0;
      mon_en   <= 1'b0;
      run      <= 1'b0;
      aen      <= 1'b0;
      arst     <= 1'b0;
      set_pend <= 1'b0;
      set_tgl  <= 1'b0;
      cap_pend <= 1'b0;
      cap_tgl  <= 1'b0;
      fail_q   <= 1'b0;
      alrm_q   <= 1'b0;
      evt_d    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        osc_en <= reg_wdata[B_OSC];
        mon_en <= reg_wdata[B_MON];
        run    <= reg_wdata[B_RUN];
        aen    <= reg_wdata[B_AEN];
        arst   <= reg_wdata[B_ALRM];
      end

      if (ctl_wr && reg_wdata[B_SET] && !set_pend) begin
        set_tgl  <= ~set_tgl;
        set_pend <= 1'b1;
      end else if (set_pend && (set_ack_s == set_tgl)) begin
        set_pend <= 1'b0;
      end

      if (ctl_wr && reg_wdata[B_CAP] && !cap_pend) begin
        cap_tgl  <= ~cap_tgl;
        cap_pend <= 1'b1;
      end else if (cap_done) begin
        cap_pend <= 1'b0;
      end

      if (mon_timeout) fail_q <= 1'b1;
      else if (ctl_wr && !reg_wdata[B_FAIL]) fail_q <= 1'b0;

      evt_d <= evt_s;
      if (ctl_wr) alrm_q <= 1'b0;
      else if (evt_s && !evt_d) alrm_q <= 1'b1;
      else if (!evt_s && evt_d) alrm_q <= 1'b0;
    end
  end

  rtc_sync #(.W(4)) u_sync_bus (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({set_ack_t, cap_ack_t, evt, beat}),
    .q    ({set_ack_s, cap_ack_s, evt_s, beat_s})
  );

  rtc_core #(.CNT_W(CNT_W)) u_core (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .osc_en_a (osc_en),
    .run_a    (run),
    .aen_a    (aen),
    .arst_a   (arst),
    .set_tgl_a(set_tgl),
    .cap_tgl_a(cap_tgl),
    .hold_val (hold_w),
    .alarm_val(alarm_w),
    .set_ack_t(set_ack_t),
    .cap_ack_t(cap_ack_t),
    .cap_val  (cap_val),
    .evt      (evt),
    .beat     (beat)
  );

  rtc_clkmon #(.LIMIT(MISS_LIMIT)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (mon_en),
    .beat_s (beat_s),
    .timeout(mon_timeout)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(HOLD_BASE + i))  reg_rdata = hold_b[i];
      if (reg_addr == ADDR_W'(ALARM_BASE + i)) reg_rdata = alarm_b[i];
    end
    if (reg_addr == ADDR_W'(CTL_OFS))
      reg_rdata = {osc_en, mon_en, fail_q, run, aen, alrm_q, set_pend, cap_pend};
  end
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              set_pend,
  input logic              set_tgl,
  input logic              set_ack_s,
  input logic              cap_pend,
  input logic              cap_tgl,
  input logic              cap_ack_s,
  input logic              alrm_q,
  input logic              evt_s,
  input logic              fail_q,
  input logic              mon_timeout
);
  logic ctl_w;
  assign ctl_w = reg_wr && (reg_addr == ADDR_W'(CTL_OFS));

  // R4
  set_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(set_pend) |-> $past(ctl_w && reg_wdata[B_SET]));

  // R4
  set_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(set_tgl) |-> $rose(set_pend));

  // R4
  set_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(set_pend) |-> $past(set_ack_s == set_tgl));

  // R5
  cap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_pend) |-> $past(cap_ack_s == cap_tgl));

  // R7
  alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alrm_q) |-> $past(evt_s));

  // R8
  alarm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w |=> !alrm_q);

  // R10
  fail_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> $past(mon_timeout));

  // R10
  fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !reg_wdata[B_FAIL] && !mon_timeout) |=> !fail_q);
endmodule

bind rtc_timer rtc_timer_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rtc_timer_tb.sv
module rtc_timer_tb;
  logic       clk = 1'b0;
  logic       slow_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [7:0] ctl_sh = '0;

  typedef struct {
    string       req;
    logic [31:0] lo;
    logic [31:0] hi;
  } exp_t;
  exp_t        exp_q[$];
  logic [31:0] obs_val;
  event        obs_ev;

  always #2 clk = ~clk;
  initial begin
    #1;
    forever #32 slow_clk = ~slow_clk;
  end

  rtc_timer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // monitor: compares each observed value against the next expectation
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        vectors++;
        if (obs_val < it.lo || obs_val > it.hi) begin
          errs++;
          $display("FAIL %s: got %0h expected %0h..%0h", it.req, obs_val, it.lo, it.hi);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
  endtask

  // control write keeps bit 5 at 1 so the fail flag is untouched
  task automatic wr_ctl(input logic [7:0] extra);
    wr(4'h4, ctl_sh | 8'h20 | extra);
  endtask

  task automatic post(input string r, input logic [31:0] v, input logic [31:0] lo, input logic [31:0] hi);
    exp_t it;
    it.req = r; it.lo = lo; it.hi = hi;
    exp_q.push_back(it);
    obs_val = v;
    ->obs_ev;
    #0;
  endtask

  task automatic exp_rd(input string r, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    post(r, {24'h0, v}, {24'h0, e}, {24'h0, e});
  endtask

  task automatic poll(input logic [7:0] mask, input logic [7:0] want, output bit ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int i = 0; i < 800 && !ok; i++) begin
      rd(4'h4, v);
      if ((v & mask) == want) ok = 1'b1;
    end
  endtask

  task automatic load_hold(input logic [31:0] val);
    for (int i = 0; i < 4; i++) wr(4'(i), val[8*i +: 8]);
  endtask

  task automatic load_alarm(input logic [31:0] val);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), val[8*i +: 8]);
  endtask

  task automatic do_set(input string r, input logic [31:0] val);
    bit ok;
    load_hold(val);
    wr_ctl(8'h02);
    poll(8'h02, 8'h00, ok);
    post(r, {31'h0, ok}, 32'd1, 32'd1);
  endtask

  task automatic exp_cnt(input string r, input logic [31:0] lo, input logic [31:0] hi);
    bit ok;
    logic [31:0] val;
    logic [7:0]  v;
    wr_ctl(8'h01);
    poll(8'h01, 8'h00, ok);
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), v);
      val[8*i +: 8] = v;
    end
    if (!ok) val = 32'hdead_beef;
    post(r, val, lo, hi);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit ok;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1: reset values
    exp_rd("R1 control", 4'h4, 8'h00);
    exp_rd("R1 hold byte", 4'h0, 8'h00);
    exp_rd("R1 alarm byte", 4'hB, 8'h00);

    // R2: byte order and read-back
    ctl_sh = 8'h80;
    wr_ctl(8'h00);
    load_hold(32'h1234_5678);
    load_alarm(32'hA1B2_C3D4);
    exp_rd("R2 hold byte 2", 4'h2, 8'h34);
    exp_rd("R2 alarm byte 0", 4'h8, 8'hD4);

    // R4: pending visible immediately, then load completes
    wr_ctl(8'h02);
    exp_rd("R4 pending", 4'h4, 8'h82);
    poll(8'h02, 8'h00, ok);
    post("R4 self-clear", {31'h0, ok}, 32'd1, 32'd1);
    // R5: capture of a stopped counter
    exp_cnt("R5 capture", 32'h1234_5678, 32'h1234_5678);
    idle(120);
    exp_cnt("R3 stopped holds", 32'h1234_5678, 32'h1234_5678);

    // R3: running
    ctl_sh = 8'h90;
    wr_ctl(8'h00);
    idle(320);
    ctl_sh = 8'h80;
    wr_ctl(8'h00);
    exp_cnt("R3 running", 32'h1234_5678 + 10, 32'h1234_5678 + 40);

    // R6: bit 2 writes auto-reset, reads flag
    ctl_sh = 8'h84;
    wr_ctl(8'h00);
    exp_rd("R6 bit2 read", 4'h4, 8'h80);

    // R7, R9: alarm with auto-reset
    do_set("R4 set 100", 32'd100);
    load_alarm(32'd110);
    ctl_sh = 8'h9C;
    wr_ctl(8'h00);
    poll(8'h04, 8'h04, ok);
    post("R7 flag raised", {31'h0, ok}, 32'd1, 32'd1);
    idle(48);
    exp_rd("R7 flag short", 4'h4, 8'h98);
    ctl_sh = 8'h8C;
    wr_ctl(8'h00);
    exp_cnt("R9 auto-reset", 32'd1, 32'd40);

    // R8, R9: no auto-reset, control write clears flag
    ctl_sh = 8'h88;
    wr_ctl(8'h00);
    do_set("R4 set 100 again", 32'd100);
    ctl_sh = 8'h98;
    wr_ctl(8'h00);
    poll(8'h04, 8'h04, ok);
    post("R7 flag again", {31'h0, ok}, 32'd1, 32'd1);
    wr_ctl(8'h00);
    exp_rd("R8 write clears", 4'h4, 8'h98);
    idle(160);
    ctl_sh = 8'h80;
    wr_ctl(8'h00);
    exp_cnt("R9 no auto-reset", 32'd111, 32'd200);

    // R11: oscillator off freezes the slow domain
    ctl_sh = 8'h00;
    wr_ctl(8'h00);
    idle(100);
    load_hold(32'd5);
    wr_ctl(8'h02);
    idle(300);
    exp_rd("R11 load waits", 4'h4, 8'h02);
    ctl_sh = 8'h80;
    wr_ctl(8'h00);
    poll(8'h02, 8'h00, ok);
    post("R11 load resumes", {31'h0, ok}, 32'd1, 32'd1);
    exp_cnt("R11 loaded value", 32'd5, 32'd5);

    // R10: missing-clock detector
    ctl_sh = 8'hC0;
    wr_ctl(8'h00);
    idle(2000);
    exp_rd("R10 no fail with clock", 4'h4, 8'hC0);
    ctl_sh = 8'h40;
    wr_ctl(8'h00);
    idle(1400);
    exp_rd("R10 fail set", 4'h4, 8'h60);
    wr_ctl(8'h00);
    exp_rd("R10 write 1 keeps", 4'h4, 8'h60);
    wr(4'h4, 8'h40);
    exp_rd("R10 write 0 clears", 4'h4, 8'h40);

    idle(10);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule